// File: doc/BRIEF.md
# Serial ROM Read Sequencer

This block fetches a run of bytes from a bit-serial EEPROM. It drives the memory through a serial clock, a serial data output and two access-enable lines, and it listens on one serial data input. A single start pulse carries a 16-bit byte offset, a per-device base offset and a byte count. The block first opens access with an ordered two-line handshake. It then shifts out the read command and the address, clocks in the requested bytes and hands each byte to the consumer over a valid/ready stream. At the end it closes access with the reverse handshake and pulses `done`.

Every control-line change is a phase that lasts `HALF_DIV` system clocks. An output bit uses three phases: data set, clock high, clock low. An input bit uses two phases: clock high, with the sample taken in its last cycle, then clock low. If the consumer holds `rd_ready` low, the sequencer parks with the serial clock low and the current byte on `rd_data`. It does not clock the next bit until that byte is taken, so no data is ever lost. A request made while the memory reports itself absent is refused without touching any line.

Top module: `serial_rom_reader`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rd_valid`, `en_hi`, `eclk` and `edo` are 0 and `en_lo` is 1.
- R2: An accepted start raises `en_hi` in the next cycle, and `en_lo` falls exactly `HALF_DIV` cycles later. `en_lo` never falls while `en_hi` is low.
- R3: After the enable handshake the block sends the command byte 0x03, then the address high byte, then the address low byte, MSB first. For each bit, `edo` takes the bit for one phase, then `eclk` is high for one phase, then low for one phase. Each phase lasts `HALF_DIV` cycles, and `edo` never changes on a rising `eclk`.
- R4: The address sent equals `offset + base` modulo 2^16, captured at the start.
- R5: Each input bit raises `eclk` for `HALF_DIV` cycles, samples `edi` in the last cycle of that phase, and then lowers `eclk` for `HALF_DIV` cycles. Bits arrive MSB first and are shifted in at the LSB.
- R6: Exactly `count` bytes are delivered. With `count` = 0 the block goes from the last address bit straight to the disable handshake.
- R7: A byte is offered with `rd_valid` = 1. While `rd_ready` is 0, `rd_valid` stays 1, `rd_data` stays stable and `eclk` stays low. The byte is taken on a clock edge where both are 1.
- R8: After the last byte is taken, `en_lo` rises, and `HALF_DIV` cycles later `en_hi` falls. `HALF_DIV` cycles after that, `done` pulses for one cycle and `busy` goes low.
- R9: A start while `present` is 0 or `missing` is 1 gives a one-cycle `err` pulse in the next cycle. `busy` stays 0 and no serial line changes.
- R10: A start pulse while `busy` is 1 has no effect on the lines, the address or the data of the running transaction.
- R11: `busy` is 1 from the cycle after an accepted start until `done`. `edo` changes only when a data-set phase is entered and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| offset | input | ADDR_W | Byte offset of the first byte |
| base | input | ADDR_W | Per-device base added to the offset |
| count | input | CNT_W | Number of bytes to read |
| present | input | 1 | Memory reports itself fitted |
| missing | input | 1 | Memory reports itself absent |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse after the disable handshake |
| err | output | 1 | One-cycle pulse for a refused request |
| rd_valid | output | 1 | Byte available on rd_data |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Received byte |
| eclk | output | 1 | Serial clock to the memory |
| edo | output | 1 | Serial data to the memory |
| edi | input | 1 | Serial data from the memory |
| en_hi | output | 1 | Access-enable line, driven high to open |
| en_lo | output | 1 | Access-enable line, driven low to open |

## Verification
The hardest case to reach is a consumer stall that lands exactly between two bytes. Here the sequencer must stop with the serial clock low and resume without a lost or repeated bit. The same point also decides whether the disable handshake follows the final byte at the right time. The bench reaches it with a ready pattern that accepts only one cycle in four, against a behavioural memory that decodes the command and address from `edo` and answers with address-dependent data. A stray start pulse is also injected in the middle of such a stalled transaction.

// File: rtl/srr_pkg.sv
package srr_pkg;
  localparam logic [7:0] SRR_CMD_READ = 8'h03;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EN_HI,
    ST_EN_LO,
    ST_TX_SET,
    ST_TX_RISE,
    ST_TX_FALL,
    ST_RX_RISE,
    ST_RX_FALL,
    ST_HOLD,
    ST_DIS_LO,
    ST_DIS_HI
  } srr_state_t;
endpackage

// File: rtl/srr_phase_timer.sv
module srr_phase_timer #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic last
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST_VAL = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign last = (cnt_q == LAST_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear)     cnt_q <= '0;
    else if (!last)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/srr_tx_shift.sv
module srr_tx_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q;

  assign msb = sr_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (load)   sr_q <= din;
    else if (shift)  sr_q <= {sr_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/srr_rx_shift.sv
module srr_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (sample)  q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
  import srr_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  logic              present,
  input  logic              missing,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              eclk,
  output logic              edo,
  input  logic              edi,
  output logic              en_hi,
  output logic              en_lo
);
  localparam int FRAME_W = 8 + ADDR_W;
  localparam int BC_W    = $clog2(FRAME_W);
  localparam logic [BC_W-1:0] TX_LAST = BC_W'(FRAME_W - 1);
  localparam logic [BC_W-1:0] RX_LAST = BC_W'(7);

  srr_state_t        state_q;
  logic [BC_W-1:0]   bit_q;
  logic [CNT_W-1:0]  left_q;
  logic              hi_q, lo_q, clk_q, do_q, valid_q, done_q, err_q;

  logic timed, adv, tlast, tclr;
  logic can_go, accept, tx_shift, rx_sample, tx_msb;
  logic [ADDR_W-1:0] addr_sum;

  assign timed     = (state_q != ST_IDLE) && (state_q != ST_HOLD);
  assign adv       = timed && tlast;
  assign tclr      = !timed || adv;
  assign can_go    = present && !missing;
  assign accept    = (state_q == ST_IDLE) && start && can_go;
  assign addr_sum  = offset + base;
  assign tx_shift  = adv && ((state_q == ST_EN_LO) ||
                             ((state_q == ST_TX_FALL) && (bit_q != TX_LAST)));
  assign rx_sample = adv && (state_q == ST_RX_RISE);

  srr_phase_timer #(.DIV(HALF_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tclr),
    .last  (tlast)
  );

  srr_tx_shift #(.W(FRAME_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   ({SRR_CMD_READ, addr_sum}),
    .shift (tx_shift),
    .msb   (tx_msb)
  );

  srr_rx_shift #(.W(8)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (rx_sample),
    .din    (edi),
    .q      (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      left_q  <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b1;
      clk_q   <= 1'b0;
      do_q    <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (!can_go) begin
              err_q <= 1'b1;
            end else begin
              state_q <= ST_EN_HI;
              hi_q    <= 1'b1;
              left_q  <= count;
            end
          end
        end
        ST_EN_HI: if (adv) begin
          state_q <= ST_EN_LO;
          lo_q    <= 1'b0;
        end
        ST_EN_LO: if (adv) begin
          state_q <= ST_TX_SET;
          do_q    <= tx_msb;
          bit_q   <= '0;
        end
        ST_TX_SET: if (adv) begin
          state_q <= ST_TX_RISE;
          clk_q   <= 1'b1;
        end
        ST_TX_RISE: if (adv) begin
          state_q <= ST_TX_FALL;
          clk_q   <= 1'b0;
        end
        ST_TX_FALL: if (adv) begin
          if (bit_q == TX_LAST) begin
            bit_q <= '0;
            if (left_q == '0) begin
              state_q <= ST_DIS_LO;
              lo_q    <= 1'b1;
            end else begin
              state_q <= ST_RX_RISE;
              clk_q   <= 1'b1;
            end
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_TX_SET;
            do_q    <= tx_msb;
          end
        end
        ST_RX_RISE: if (adv) begin
          state_q <= ST_RX_FALL;
          clk_q   <= 1'b0;
        end
        ST_RX_FALL: if (adv) begin
          if (bit_q == RX_LAST) begin
            bit_q   <= '0;
            state_q <= ST_HOLD;
            valid_q <= 1'b1;
            left_q  <= left_q - 1'b1;
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_RX_RISE;
            clk_q   <= 1'b1;
          end
        end
        ST_HOLD: if (rd_ready) begin
          valid_q <= 1'b0;
          if (left_q == '0) begin
            state_q <= ST_DIS_LO;
            lo_q    <= 1'b1;
          end else begin
            state_q <= ST_RX_RISE;
            clk_q   <= 1'b1;
          end
        end
        ST_DIS_LO: if (adv) begin
          state_q <= ST_DIS_HI;
          hi_q    <= 1'b0;
        end
        ST_DIS_HI: if (adv) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign rd_valid = valid_q;
  assign eclk     = clk_q;
  assign edo      = do_q;
  assign en_hi    = hi_q;
  assign en_lo    = lo_q;
endmodule

module srr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       eclk,
  input logic       edo,
  input logic       en_hi,
  input logic       en_lo
);
  assert_enable_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_lo) |-> (en_hi && $past(en_hi)));

  assert_disable_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_hi) |-> (en_lo && $past(en_lo)));

  assert_clock_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eclk |-> (en_hi && !en_lo));

  assert_data_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eclk) |-> $stable(edo));

  assert_edo_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(edo) |-> (busy && !eclk));

  assert_hold_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !eclk);

  assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!en_hi && en_lo && !eclk && !rd_valid));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_reject_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));
endmodule

bind serial_rom_reader srr_checker u_srr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .eclk     (eclk),
  .edo      (edo),
  .en_hi    (en_hi),
  .en_lo    (en_lo)
);

// File: tb/serial_rom_reader_bench.sv
module serial_rom_reader_bench;
  localparam int DIV = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] r_off = '0, r_base = '0, r_cnt = '0;
  logic        present = 1'b1, missing = 1'b0;
  logic        busy, done, err, rd_valid, eclk, edo, en_hi, en_lo;
  logic        rd_ready = 1'b1;
  logic        edi = 1'b0;
  logic [7:0]  rd_data;

  serial_rom_reader #(.HALF_DIV(DIV), .ADDR_W(16), .CNT_W(16)) u_serial_rom_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(r_off), .base(r_base),
    .count(r_cnt), .present(present), .missing(missing), .busy(busy),
    .done(done), .err(err), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .eclk(eclk), .edo(edo), .edi(edi), .en_hi(en_hi),
    .en_lo(en_lo)
  );

  int tests = 0, fails = 0;

  // expected port values, advanced by the behavioural model
  logic x_busy = 0, x_done = 0, x_err = 0, x_valid = 0, x_clk = 0, x_do = 0;
  logic x_hi = 0, x_lo = 1;
  logic [7:0] x_data = '0;
  bit   cmp_en = 0, pend = 0, stall = 0;
  int   cyc = 0;

  logic [7:0] got_q[$];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] romf(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  // behavioural serial memory: decodes command and address, answers with data
  int          sl_n = 0;
  int          sl_idx;
  logic [23:0] sl_frame = '0;
  logic [7:0]  sl_byte;
  logic [7:0]  seen_cmd = '0;
  logic [15:0] seen_addr = '0;

  always @(posedge en_lo) sl_n = 0;

  always @(posedge eclk) begin
    if (sl_n < 24) begin
      sl_frame = {sl_frame[22:0], edo};
      if (sl_n == 23) begin
        seen_cmd  = sl_frame[23:16];
        seen_addr = sl_frame[15:0];
      end
    end else begin
      sl_idx  = sl_n - 24;
      sl_byte = romf(seen_addr + 16'(sl_idx / 8));
      edi     = sl_byte[7 - (sl_idx % 8)];
    end
    sl_n++;
  end

  always @(negedge clk) begin
    cyc++;
    rd_ready = stall ? (cyc % 4 == 0) : 1'b1;
  end

  always @(posedge clk)
    if (rst_n && rd_valid && rd_ready) got_q.push_back(rd_data);

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2", "en_hi", en_hi, x_hi);
      chk("R8", "en_lo", en_lo, x_lo);
      chk("R3", "eclk", eclk, x_clk);
      chk("R3", "edo", edo, x_do);
      chk("R11", "busy", busy, x_busy);
      chk("R8", "done", done, x_done);
      chk("R9", "err", err, x_err);
      chk("R7", "rd_valid", rd_valid, x_valid);
      if (x_valid) chk("R7", "rd_data", rd_data, x_data);
    end
  end

  task automatic step();
    repeat (DIV) @(posedge clk);
    #1;
  endtask

  task automatic enter();
    if (pend) step();
    pend = 1;
  endtask

  task automatic run_txn(input logic [15:0] off, input logic [15:0] bs,
                         input logic [15:0] cnt, input bit inject);
    logic [15:0] addr;
    logic [23:0] fr;
    addr = off + bs;
    fr   = {8'h03, addr};
    got_q.delete();
    @(negedge clk);
    r_off = off; r_base = bs; r_cnt = cnt; start = 1;
    fork
      begin
        @(posedge clk); #1;
        start = 0; x_busy = 1; x_hi = 1; pend = 1;
        enter(); x_lo = 0;
        for (int i = 0; i < 24; i++) begin
          enter(); x_do  = fr[23-i];
          enter(); x_clk = 1;
          enter(); x_clk = 0;
        end
        for (int k = 0; k < cnt; k++) begin
          for (int b = 0; b < 8; b++) begin
            enter(); x_clk = 1;
            enter(); x_clk = 0;
          end
          enter(); x_valid = 1; x_data = romf(addr + 16'(k));
          do @(posedge clk); while (!rd_ready);
          #1; x_valid = 0; pend = 0;
        end
        enter(); x_lo = 1;
        enter(); x_hi = 0;
        enter(); x_busy = 0; x_done = 1;
        @(posedge clk); #1; x_done = 0;
      end
      begin
        if (inject) begin
          repeat (40) @(negedge clk);
          start = 1; r_off = 16'h7777; r_cnt = 16'd9;  // R10 stray request
          @(negedge clk);
          start = 0;
        end
      end
    join
    @(negedge clk);
    chk("R3", "command byte", seen_cmd, 8'h03);
    chk("R4", "address sent", seen_addr, addr);
    chk("R6", "byte count", got_q.size(), cnt);
    for (int k = 0; k < got_q.size() && k < cnt; k++)
      chk("R5", "byte value", got_q[k], romf(addr + 16'(k)));
  endtask

  task automatic run_reject(input bit pres, input bit miss);
    @(negedge clk);
    present = pres; missing = miss; start = 1;
    @(posedge clk); #1;
    start = 0; x_err = 1;
    @(posedge clk); #1;
    x_err = 0;
    repeat (5) @(negedge clk);
    chk("R9", "busy after refusal", busy, 1'b0);
    chk("R9", "en_hi after refusal", en_hi, 1'b0);
    present = 1; missing = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "en_hi", en_hi, 0);
    chk("R1", "en_lo", en_lo, 1);
    chk("R1", "eclk", eclk, 0);
    chk("R1", "edo", edo, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    cmp_en = 1;

    run_txn(16'h0010, 16'h0100, 16'd3, 0);      // plain read, ready always high
    run_txn(16'h0005, 16'h0000, 16'd0, 0);      // R6 zero count
    stall = 1;
    run_txn(16'hFFF0, 16'h0020, 16'd2, 1);      // R4 wrap, R7 stalls, R10 stray start
    run_txn(16'hA5C3, 16'h1111, 16'd4, 0);      // R7 stalls across several bytes
    stall = 0;
    run_reject(1'b0, 1'b0);                     // R9 not present
    run_reject(1'b1, 1'b1);                     // R9 flagged missing
    run_txn(16'h0001, 16'h0002, 16'd1, 0);      // normal after refusals

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule